// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Majority Noise Filter

This block receives asynchronous serial frames on a single input line. Every system clock it samples the line, and a three-sample majority vote removes short glitches. After the optional line inversion, the block watches the filtered level for the edge that opens a start bit. That edge restarts a bit-timing counter at half a bit period, so the start bit and every bit after it are sampled near the centre of its bit time.

The frame format is set by inputs. The data length can be 5 to 9 bits, sent least- or most-significant bit first. In normal mode an optional parity bit follows the data, with even or odd sense. In multiprocessor mode an address-marker bit follows the data in place of parity. The duration of one bit in system clocks is also an input.

Once the first stop bit has been sampled, the received word is presented and a data-full flag is raised. A read strobe empties the word. Parity, framing and overrun errors each stay latched until a separate clear strobe is given.

Top module: `async_rx_majority`

## Requirements
- R1: The line is sampled once per clock and the majority of the three most recent samples is used. A single-clock pulse to the space level on an idle line starts no reception. A two-clock pulse does start one.
- R2: A frame starts only on a mark-to-space transition of the filtered line while `rxEnable` is 1. With `rxEnable` at 0 the receiver stays idle, and any frame in progress is abandoned.
- R3: The start edge loads the bit counter with half of `clksPerBit`. Each later bit is sampled `clksPerBit` clocks after the one before it, so a bit is decoded correctly even when its first and last three clocks carry the opposite value.
- R4: `dataFull` rises when the first stop bit is sampled. No later stop bit is waited for. `rxData` holds the new word from then on.
- R5: `dataLen` (5..9) sets how many data bits are taken. Unused upper bits of `rxData` read 0. `msbFirst`=0 maps the first received data bit to bit 0, and `msbFirst`=1 maps it to bit `dataLen`-1.
- R6: In normal mode (`mpMode`=0) with `parityEn`=1, one parity bit follows the data. `parityErr` is set when the count of ones over data plus parity is odd with `parityOdd`=0, or even with `parityOdd`=1.
- R7: With `mpMode`=1, exactly one bit follows the data whatever `parityEn` is. That bit is presented on `addrFlag`, and no parity error is ever raised.
- R8: With `invertLine`=1 the line is read inverted. Idle is then 0, a start bit is 1, and every data value is the complement of the level on the pin.
- R9: A first stop bit sampled at space (logic 0 after inversion) sets `framingErr`. The word is still delivered.
- R10: A frame that completes while `dataFull` is 1 and no read is given sets `overrunErr`. `rxData` and `addrFlag` keep the older word.
- R11: A `readStrobe` pulse clears `dataFull` on the next clock, unless a frame completes in that same cycle.
- R12: `parityErr`, `framingErr` and `overrunErr` stay at 1 through later good frames until `errClear` is pulsed.
- R13: After reset, `rxData` is 0 and `dataFull` and all three error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxEnable | input | 1 | Allows frames to start; 0 forces idle |
| serialIn | input | 1 | Raw serial line |
| clksPerBit | input | CPB_W | System clocks per bit (at least 4) |
| dataLen | input | LEN_W | Number of data bits, 5..MAX_DATA_BITS |
| parityEn | input | 1 | Parity bit present (normal mode) |
| parityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| msbFirst | input | 1 | 1 = first data bit is the most significant |
| invertLine | input | 1 | 1 = line level is inverted |
| mpMode | input | 1 | 1 = multiprocessor mode with address bit |
| readStrobe | input | 1 | Consumes the received word |
| errClear | input | 1 | Clears the three error flags |
| rxData | output | MAX_DATA_BITS | Received word, right aligned |
| addrFlag | output | 1 | Address bit of the last multiprocessor frame |
| dataFull | output | 1 | A received word is waiting |
| parityErr | output | 1 | Sticky parity error |
| framingErr | output | 1 | Sticky framing error |
| overrunErr | output | 1 | Sticky overrun error |

## Verification
The hardest behaviour to reach from the ports is mid-bit sampling. A clean waveform decodes correctly even if the sampling point drifts badly toward the bit edges. To expose drift, the stimulus drives frames with a long bit time in which the first and last three clocks of every data bit carry the opposite value. Those stretches are long enough to pass the majority filter, so only a sampling point near the bit centre returns the intended word.

Filter boundaries are reached with isolated one- and two-clock pulses on an idle line. The main sweep crosses every data length, both bit orders, three parity settings and both line polarities, and deliberately corrupts the parity bit on alternate frames.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_EXTRA,
    RX_STOP
  } rxState_t;

  // Sampling strobes from the frame controller to the datapath
  typedef struct packed {
    logic takeData;
    logic takeExtra;
    logic takeStop;
  } rxStrobe_t;

endpackage

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import async_rx_pkg::*;
#(
  parameter int MAX_DATA_BITS = 9,
  parameter int CPB_W         = 16,
  parameter int LEN_W         = $clog2(MAX_DATA_BITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic             startEdge,
  input  logic [CPB_W-1:0] clksPerBit,
  input  logic [LEN_W-1:0] dataLen,
  input  logic             parityEn,
  input  logic             mpMode,
  output rxStrobe_t        strobe
);

  rxState_t         state;
  logic [CPB_W-1:0] cnt;
  logic [LEN_W-1:0] bitIdx;
  logic             tick;
  logic             lastBit;
  logic             wantExtra;

  assign tick      = (state != RX_IDLE) && (cnt == '0);
  assign lastBit   = (bitIdx == dataLen - LEN_W'(1));
  assign wantExtra = parityEn | mpMode;

  always_comb begin
    strobe           = '0;
    strobe.takeData  = tick && (state == RX_DATA);
    strobe.takeExtra = tick && (state == RX_EXTRA);
    strobe.takeStop  = tick && (state == RX_STOP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= RX_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (!rxEnable) begin
      state  <= RX_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      case (state)
        RX_IDLE: begin
          if (startEdge) begin
            // Restart bit timing at the edge: first sample lands mid start bit
            state <= RX_START;
            cnt   <= (clksPerBit >> 1) - CPB_W'(1);
          end
        end
        default: begin
          if (!tick) begin
            cnt <= cnt - CPB_W'(1);
          end else begin
            cnt <= clksPerBit - CPB_W'(1);
            case (state)
              RX_START: begin
                state  <= RX_DATA;
                bitIdx <= '0;
              end
              RX_DATA: begin
                if (lastBit) state <= wantExtra ? RX_EXTRA : RX_STOP;
                else         bitIdx <= bitIdx + LEN_W'(1);
              end
              RX_EXTRA: state <= RX_STOP;
              default:  state <= RX_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  // R2: disabling the receiver returns it to idle
  p_idle_when_disabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (state == RX_IDLE));

  // R2: no frame begins without a start edge from the filter
  p_edge_needed_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_IDLE && !startEdge) |=> (state == RX_IDLE));

  // R4: only the first stop bit is sampled, then the receiver is idle again
  p_one_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeStop |=> (state == RX_IDLE));

endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import async_rx_pkg::*;
#(
  parameter int MAX_DATA_BITS = 9,
  parameter int LEN_W         = $clog2(MAX_DATA_BITS + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     serialIn,
  input  logic                     invertLine,
  input  logic [LEN_W-1:0]         dataLen,
  input  logic                     parityEn,
  input  logic                     parityOdd,
  input  logic                     msbFirst,
  input  logic                     mpMode,
  input  logic                     readStrobe,
  input  logic                     errClear,
  input  rxStrobe_t                strobe,
  output logic                     startEdge,
  output logic [MAX_DATA_BITS-1:0] rxData,
  output logic                     addrFlag,
  output logic                     dataFull,
  output logic                     parityErr,
  output logic                     framingErr,
  output logic                     overrunErr
);

  localparam int MB = MAX_DATA_BITS;

  logic [2:0]    samp;
  logic          filt;
  logic          lineLevel;
  logic          prevLevel;
  logic [MB-1:0] shiftReg;
  logic          extraBit;
  logic [LEN_W-1:0] shAmt;
  logic [MB-1:0] lenMask;
  logic [MB-1:0] assembled;
  logic          parityBad;
  logic          overrunNow;

  // Three-sample majority filter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      samp      <= '1;
      filt      <= 1'b1;
      prevLevel <= 1'b0;
    end else begin
      samp      <= {samp[1:0], serialIn};
      filt      <= (samp[0] & samp[1]) | (samp[0] & samp[2]) | (samp[1] & samp[2]);
      prevLevel <= lineLevel;
    end
  end

  assign lineLevel = filt ^ invertLine;
  assign startEdge = prevLevel & ~lineLevel;

  // Bit collection: one register serves both bit orders
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      extraBit <= 1'b0;
    end else begin
      if (strobe.takeData) begin
        if (msbFirst) shiftReg <= {shiftReg[MB-2:0], lineLevel};
        else          shiftReg <= {lineLevel, shiftReg[MB-1:1]};
      end
      if (strobe.takeExtra) extraBit <= lineLevel;
    end
  end

  assign shAmt     = LEN_W'(MB) - dataLen;
  assign lenMask   = {MB{1'b1}} >> shAmt;
  assign assembled = msbFirst ? (shiftReg & lenMask) : (shiftReg >> shAmt);
  assign parityBad = parityEn && !mpMode && ((^assembled ^ extraBit) != parityOdd);
  assign overrunNow = dataFull && !readStrobe;

  // Word, flags and errors
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      addrFlag   <= 1'b0;
      dataFull   <= 1'b0;
      parityErr  <= 1'b0;
      framingErr <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      if (errClear) begin
        parityErr  <= 1'b0;
        framingErr <= 1'b0;
        overrunErr <= 1'b0;
      end
      if (strobe.takeStop) begin
        if (overrunNow) begin
          overrunErr <= 1'b1;
        end else begin
          rxData   <= assembled;
          addrFlag <= mpMode & extraBit;
          dataFull <= 1'b1;
          if (parityBad)  parityErr  <= 1'b1;
          if (!lineLevel) framingErr <= 1'b1;
        end
      end else if (readStrobe) begin
        dataFull <= 1'b0;
      end
    end
  end

  // R4: a sampled stop bit leaves a full word behind
  p_full_on_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeStop |=> dataFull);

  // R11: a read with no completing frame empties the word
  p_read_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobe && !strobe.takeStop) |=> !dataFull);

  // R10: overrun keeps the older word
  p_overrun_keeps_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeStop && dataFull && !readStrobe) |=> (overrunErr && $stable(rxData)));

  // R7: multiprocessor frames never raise a parity error
  p_mp_no_parity_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeStop && mpMode && !parityErr) |=> !parityErr);

  // R12: error flags hold until cleared
  p_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    ((parityErr || framingErr || overrunErr) && !errClear)
      |=> (parityErr || framingErr || overrunErr));

  // R1: filter output follows an input that has been steady for three clocks
  p_filter_settles_r1: assert property (@(posedge clk) disable iff (!rstN)
    (samp == 3'b000) |=> !filt);

endmodule

// File: rtl/async_rx_majority.sv
module async_rx_majority
  import async_rx_pkg::*;
#(
  parameter int MAX_DATA_BITS = 9,
  parameter int CPB_W         = 16,
  parameter int LEN_W         = $clog2(MAX_DATA_BITS + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rxEnable,
  input  logic                     serialIn,
  input  logic [CPB_W-1:0]         clksPerBit,
  input  logic [LEN_W-1:0]         dataLen,
  input  logic                     parityEn,
  input  logic                     parityOdd,
  input  logic                     msbFirst,
  input  logic                     invertLine,
  input  logic                     mpMode,
  input  logic                     readStrobe,
  input  logic                     errClear,
  output logic [MAX_DATA_BITS-1:0] rxData,
  output logic                     addrFlag,
  output logic                     dataFull,
  output logic                     parityErr,
  output logic                     framingErr,
  output logic                     overrunErr
);

  rxStrobe_t strobe;
  logic      startEdge;

  rx_frame_ctrl #(
    .MAX_DATA_BITS(MAX_DATA_BITS),
    .CPB_W        (CPB_W),
    .LEN_W        (LEN_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rxEnable  (rxEnable),
    .startEdge (startEdge),
    .clksPerBit(clksPerBit),
    .dataLen   (dataLen),
    .parityEn  (parityEn),
    .mpMode    (mpMode),
    .strobe    (strobe)
  );

  rx_datapath #(
    .MAX_DATA_BITS(MAX_DATA_BITS),
    .LEN_W        (LEN_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .serialIn  (serialIn),
    .invertLine(invertLine),
    .dataLen   (dataLen),
    .parityEn  (parityEn),
    .parityOdd (parityOdd),
    .msbFirst  (msbFirst),
    .mpMode    (mpMode),
    .readStrobe(readStrobe),
    .errClear  (errClear),
    .strobe    (strobe),
    .startEdge (startEdge),
    .rxData    (rxData),
    .addrFlag  (addrFlag),
    .dataFull  (dataFull),
    .parityErr (parityErr),
    .framingErr(framingErr),
    .overrunErr(overrunErr)
  );

endmodule

// File: tb/async_rx_majority_tb.sv
module async_rx_majority_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxEnable = 1'b0;
  logic       serialIn = 1'b1;
  logic [15:0] clksPerBit = 16'd8;
  logic [3:0] dataLen = 4'd8;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       msbFirst = 1'b0;
  logic       invertLine = 1'b0;
  logic       mpMode = 1'b0;
  logic       readStrobe = 1'b0;
  logic       errClear = 1'b0;
  logic [8:0] rxData;
  logic       addrFlag, dataFull, parityErr, framingErr, overrunErr;

  int checks = 0;
  int fails = 0;
  int cpb = 8;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  async_rx_majority u_dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .serialIn(serialIn),
    .clksPerBit(clksPerBit), .dataLen(dataLen), .parityEn(parityEn),
    .parityOdd(parityOdd), .msbFirst(msbFirst), .invertLine(invertLine),
    .mpMode(mpMode), .readStrobe(readStrobe), .errClear(errClear),
    .rxData(rxData), .addrFlag(addrFlag), .dataFull(dataFull),
    .parityErr(parityErr), .framingErr(framingErr), .overrunErr(overrunErr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, input int clocks);
    serialIn = b ^ invertLine;
    repeat (clocks) @(negedge clk);
  endtask

  // noisy=1: first and last three clocks of each data bit are inverted (R3)
  task automatic sendFrame(input logic [8:0] d, input int len, input logic msb,
                           input logic hasExtra, input logic extra,
                           input logic stopV, input bit noisy);
    sendBit(1'b0, cpb);
    for (int i = 0; i < len; i++) begin
      logic b;
      b = msb ? d[len-1-i] : d[i];
      if (noisy) begin
        sendBit(~b, 3); sendBit(b, cpb - 6); sendBit(~b, 3);
      end else begin
        sendBit(b, cpb);
      end
    end
    if (hasExtra) sendBit(extra, cpb);
    sendBit(stopV, cpb);
    sendBit(1'b1, 2 * cpb);
  endtask

  task automatic setInv(input logic inv);
    rxEnable = 1'b0;
    invertLine = inv;
    serialIn = ~inv;
    repeat (8) @(negedge clk);
    rxEnable = 1'b1;
    @(negedge clk);
  endtask

  task automatic readAndClear();
    readStrobe = 1'b1;
    errClear = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
    errClear = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    chk("R13 rxData", int'(rxData), 0);
    chk("R13 dataFull", int'(dataFull), 0);
    chk("R13 errors", int'({parityErr, framingErr, overrunErr}), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R2: disabled receiver ignores a full frame
    sendFrame(9'h0A5, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R2 disabled no frame", int'(dataFull), 0);
    setInv(1'b0);
    repeat (40) @(negedge clk);
    chk("R2 enable alone no frame", int'(dataFull), 0);

    // R1: one-clock glitch rejected
    sendBit(1'b0, 1);
    sendBit(1'b1, 20 * cpb);
    chk("R1 1-clock glitch", int'(dataFull), 0);
    // R1: two-clock glitch passes and starts a frame of all marks
    sendBit(1'b0, 2);
    sendBit(1'b1, 15 * cpb);
    chk("R1 2-clock pulse full", int'(dataFull), 1);
    chk("R1 2-clock pulse data", int'(rxData), 255);
    readAndClear();

    // Main sweep: R5 R6 R8 R4 R11
    for (int inv = 0; inv < 2; inv++) begin
      setInv(inv[0]);
      for (int len = 5; len <= 9; len++) begin
        for (int msb = 0; msb < 2; msb++) begin
          for (int pm = 0; pm < 3; pm++) begin
            for (int k = 0; k < 4; k++) begin
              logic [8:0] v, mask, expD;
              logic pbit, bad;
              v = 9'((k * 173 + len * 29 + msb * 61 + pm * 7 + inv * 91) % 512);
              mask = 9'((1 << len) - 1);
              expD = v & mask;
              dataLen = 4'(len);
              msbFirst = msb[0];
              parityEn = (pm != 0);
              parityOdd = (pm == 2);
              bad = (pm != 0) && k[0];
              pbit = (^expD) ^ parityOdd ^ bad;
              sendFrame(v, len, msbFirst, parityEn, pbit, 1'b1, 1'b0);
              chk("R5 R8 data", int'(rxData), int'(expD));
              chk("R4 full", int'(dataFull), 1);
              chk("R6 parity error", int'(parityErr), int'(bad));
              chk("R9 no framing", int'(framingErr), 0);
              readAndClear();
              chk("R11 read clears", int'(dataFull), 0);
            end
          end
        end
      end
    end
    setInv(1'b0);
    parityEn = 1'b0;
    parityOdd = 1'b0;
    dataLen = 4'd8;
    msbFirst = 1'b0;

    // R4: full raised during first stop bit, second stop not awaited
    sendBit(1'b0, cpb);
    for (int i = 0; i < 8; i++) sendBit(1'b1, cpb);
    sendBit(1'b1, cpb);
    chk("R4 full at first stop", int'(dataFull), 1);
    sendBit(1'b1, cpb);
    readAndClear();

    // R7: multiprocessor mode, address bit, parity ignored
    mpMode = 1'b1;
    parityEn = 1'b1;
    for (int a = 0; a < 2; a++) begin
      sendFrame(9'h03C, 8, 1'b0, 1'b1, a[0], 1'b1, 1'b0);
      chk("R7 addrFlag", int'(addrFlag), a);
      chk("R7 data", int'(rxData), 60);
      chk("R7 no parity err", int'(parityErr), 0);
      readAndClear();
    end
    mpMode = 1'b0;
    parityEn = 1'b0;

    // R9: framing error, data still delivered
    sendFrame(9'h055, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 framing", int'(framingErr), 1);
    chk("R9 data", int'(rxData), 85);
    // R12: sticky through a good frame
    readStrobe = 1'b1; @(negedge clk); readStrobe = 1'b0;
    sendFrame(9'h011, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R12 framing sticky", int'(framingErr), 1);
    readAndClear();
    chk("R12 cleared", int'(framingErr), 0);

    // R10: overrun keeps older word
    sendFrame(9'h0A1, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    sendFrame(9'h05E, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R10 overrun", int'(overrunErr), 1);
    chk("R10 old data", int'(rxData), 161);
    chk("R10 still full", int'(dataFull), 1);
    errClear = 1'b1; @(negedge clk); errClear = 1'b0;
    chk("R12 overrun cleared", int'(overrunErr), 0);
    chk("R11 full kept by clear", int'(dataFull), 1);
    readAndClear();

    // R3: long bit time with corrupted bit edges
    cpb = 16;
    clksPerBit = 16'd16;
    for (int k = 0; k < 6; k++) begin
      logic [8:0] v;
      v = 9'((k * 97 + 45) % 512);
      dataLen = 4'd9;
      msbFirst = k[0];
      sendFrame(v, 9, msbFirst, 1'b0, 1'b0, 1'b1, 1'b1);
      chk("R3 mid-bit data", int'(rxData), int'(v));
      readAndClear();
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule